// File: doc/BRIEF.md
# Spaced Waveform Sample Player

This block plays a stored table of samples out to a converter through a separate serial-peripheral master. It reads the table one word at a time from a synchronous memory read port with one cycle of latency. It then hands each word to the serial master over a three-signal handshake: the master reports that it can accept work, the block raises an arm request, and the master reports that the transfer is done. After each completed transfer the block waits a programmable number of clock cycles before it fetches the next sample, so the output rate is set by the spacing value and does not depend on the memory or the serial link.

Playback is started by holding run high. The table length, the table base address, the spacing and the loop option are live inputs. In one-shot mode the block plays each sample once, raises finished and holds it until run is released. In loop mode the sample index wraps to zero after the last sample, and playback continues until run falls. The current sample index and a free-running spacing timer are visible at all times.

Top module: `wave_seq`

## Requirements
- R1: While reset is high, ready_o is 1 and finished_o, spi_arm_o, mem_rd_o, index_o and timer_o are all 0.
- R2: ready_o is 1 only while idle. When run_i is sampled high in idle with a non-zero wave_len_i, mem_rd_o is 1 and ready_o is 0 on the following cycle.
- R3: Sample k of a pass is read from address base_addr_i + 4*k with a single-cycle mem_rd_o strobe. The word the memory returns on the next cycle is presented unchanged on spi_data_o while spi_arm_o is high.
- R4: spi_arm_o rises only in the cycle after spi_ready_i was seen high. It then stays high until spi_done_i is seen, and it falls on the next clock edge.
- R5: The next mem_rd_o strobe (or the move to the end state) comes exactly spacing_i+1 cycles after the cycle in which spi_arm_o falls.
- R6: timer_o is cleared on the clock edge that completes a transfer. Otherwise it rises by one per cycle and saturates at all ones.
- R7: With loop_i at 0, exactly wave_len_i transfers are made. finished_o then rises and holds, with no further reads, while run_i stays high. One cycle after run_i falls, ready_o is 1 and finished_o is 0.
- R8: With loop_i at 1, the index wraps from wave_len_i-1 to 0 and transfers continue while run_i is high.
- R9: If run_i is low at the end of a sample's spacing wait, the block returns to idle without another read and without raising finished_o.
- R10: A wave_len_i of 0 takes idle straight to finished on the next cycle, with no read and no transfer.
- R11: index_o equals the index of the sample being fetched and sent. It reads 0 for the first sample of every pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Hold high to play |
| loop_i | input | 1 | 1 = repeat the table, 0 = one pass |
| wave_len_i | input | CW | Number of samples in the table |
| spacing_i | input | TW | Extra wait cycles after each transfer |
| base_addr_i | input | AW | Byte address of sample 0 |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_data_i | input | DW | Memory read data, valid one cycle after the strobe |
| spi_ready_i | input | 1 | Serial master can accept a transfer |
| spi_done_i | input | 1 | Serial master finished the armed transfer |
| spi_arm_o | output | 1 | Transfer request |
| spi_data_o | output | DW | Word to transmit |
| index_o | output | CW | Current sample index |
| timer_o | output | TW | Spacing timer |
| ready_o | output | 1 | Idle and able to start |
| finished_o | output | 1 | One-shot pass complete |

## Verification
Each result comes a fixed number of edges after its cause. A read strobe appears one cycle after run is sampled in idle. The fetched word is on spi_data_o by the time arm rises, two edges after the strobe at the earliest. Arm falls one edge after done. The next strobe comes spacing+1 edges after arm falls, and ready returns one edge after run falls in the end state. The bench drives inputs and samples outputs on the falling clock edge. It keeps a cycle count of rising edges and checks each gap as an exact difference of that count. It waits on arm rises (never on arm falls) before it drops run, so that its own timing cannot add a sample.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LATCH,
    ST_WAITRDY,
    ST_ARM,
    ST_SPACE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/wave_seq_gap_timer.sv
module wave_seq_gap_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  output logic [TW-1:0] count_o
);
  localparam logic [TW-1:0] TOP = {TW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_o <= '0;
    end else if (count_o != TOP) begin
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/wave_seq_index.sv
module wave_seq_index #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [CW-1:0] len_i,
  input  logic [AW-1:0] base_i,
  output logic [CW-1:0] idx_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);
  localparam int XW = CW + 1;

  logic [XW-1:0] next_count;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      idx_o <= '0;
    end else if (adv_i) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign next_count = {1'b0, idx_o} + XW'(1);
  assign last_o     = next_count >= {1'b0, len_i};
  assign addr_o     = base_i + (AW'(idx_o) << 2);
endmodule

// File: rtl/wave_seq.sv
module wave_seq #(
  parameter int CW = 16,
  parameter int TW = 16,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          loop_i,
  input  logic [CW-1:0] wave_len_i,
  input  logic [TW-1:0] spacing_i,
  input  logic [AW-1:0] base_addr_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_data_i,
  input  logic          spi_ready_i,
  input  logic          spi_done_i,
  output logic          spi_arm_o,
  output logic [DW-1:0] spi_data_o,
  output logic [CW-1:0] index_o,
  output logic [TW-1:0] timer_o,
  output logic          ready_o,
  output logic          finished_o
);
  import wave_seq_pkg::*;

  seq_state_t state_q, state_n;
  logic       idx_clr, idx_adv, tmr_clr, is_last, gap_met;

  wave_seq_index #(.CW(CW), .AW(AW)) u_index (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (idx_clr),
    .adv_i  (idx_adv),
    .len_i  (wave_len_i),
    .base_i (base_addr_i),
    .idx_o  (index_o),
    .last_o (is_last),
    .addr_o (mem_addr_o)
  );

  wave_seq_gap_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear_i (tmr_clr),
    .count_o (timer_o)
  );

  assign gap_met = timer_o >= spacing_i;

  always_comb begin
    state_n = state_q;
    idx_clr = 1'b0;
    idx_adv = 1'b0;
    tmr_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (run_i) begin
          if (wave_len_i == '0) begin
            state_n = ST_DONE;
          end else begin
            state_n = ST_FETCH;
            idx_clr = 1'b1;
          end
        end
      end
      ST_FETCH:   state_n = ST_LATCH;
      ST_LATCH:   state_n = ST_WAITRDY;
      ST_WAITRDY: if (spi_ready_i) state_n = ST_ARM;
      ST_ARM: begin
        if (spi_done_i) begin
          state_n = ST_SPACE;
          tmr_clr = 1'b1;
        end
      end
      ST_SPACE: begin
        if (gap_met) begin
          if (!run_i) begin
            state_n = ST_IDLE;
          end else if (is_last) begin
            if (loop_i) begin
              state_n = ST_FETCH;
              idx_clr = 1'b1;
            end else begin
              state_n = ST_DONE;
            end
          end else begin
            state_n = ST_FETCH;
            idx_adv = 1'b1;
          end
        end
      end
      ST_DONE:    if (!run_i) state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      spi_arm_o  <= 1'b0;
      spi_data_o <= '0;
    end else begin
      state_q <= state_n;
      if (state_q == ST_LATCH) begin
        spi_data_o <= mem_data_i;
      end
      if (state_q == ST_WAITRDY && spi_ready_i) begin
        spi_arm_o <= 1'b1;
      end else if (state_q == ST_ARM && spi_done_i) begin
        spi_arm_o <= 1'b0;
      end
    end
  end

  assign mem_rd_o   = (state_q == ST_FETCH);
  assign ready_o    = (state_q == ST_IDLE);
  assign finished_o = (state_q == ST_DONE);
endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int CW = 16,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run_i,
  input logic [CW-1:0] wave_len_i,
  input logic          spi_ready_i,
  input logic          spi_done_i,
  input logic          spi_arm_o,
  input logic          mem_rd_o,
  input logic          ready_o,
  input logic          finished_o,
  input logic [TW-1:0] timer_o
);
  assert_arm_after_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_arm_o) |-> $past(spi_ready_i));

  assert_arm_held_R4: assert property (@(posedge clk) disable iff (rst)
    (spi_arm_o && !spi_done_i) |=> spi_arm_o);

  assert_status_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(ready_o && finished_o));

  assert_read_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> (!ready_o && !finished_o && !spi_arm_o));

  assert_read_single_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |=> !mem_rd_o);

  assert_timer_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(spi_arm_o && spi_done_i) && $past(timer_o) != {TW{1'b1}})
      |-> timer_o == TW'($past(timer_o) + 1'b1));

  assert_empty_table_R10: assert property (@(posedge clk) disable iff (rst)
    (ready_o && run_i && wave_len_i == '0) |=> (finished_o && !mem_rd_o));
endmodule

bind wave_seq wave_seq_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_i       (run_i),
  .wave_len_i  (wave_len_i),
  .spi_ready_i (spi_ready_i),
  .spi_done_i  (spi_done_i),
  .spi_arm_o   (spi_arm_o),
  .mem_rd_o    (mem_rd_o),
  .ready_o     (ready_o),
  .finished_o  (finished_o),
  .timer_o     (timer_o)
);

// File: tb/wave_seq_bench.sv
module wave_seq_bench;
  localparam int CW = 16;
  localparam int TW = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          loop_en = 1'b0;
  logic [CW-1:0] wlen = '0;
  logic [TW-1:0] spacing = '0;
  logic [AW-1:0] base = '0;
  logic          mem_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_q = '0;
  logic          spi_ready = 1'b1;
  logic          spi_done = 1'b0;
  logic          spi_arm_o;
  logic [DW-1:0] spi_data_o;
  logic [CW-1:0] index_o;
  logic [TW-1:0] timer_o;
  logic          ready_o;
  logic          finished_o;

  always #2.5 clk = ~clk;

  wave_seq #(.CW(CW), .TW(TW), .AW(AW), .DW(DW)) u_wave_seq (
    .clk(clk), .rst(rst), .run_i(run), .loop_i(loop_en), .wave_len_i(wlen),
    .spacing_i(spacing), .base_addr_i(base), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_q), .spi_ready_i(spi_ready),
    .spi_done_i(spi_done), .spi_arm_o(spi_arm_o), .spi_data_o(spi_data_o),
    .index_o(index_o), .timer_o(timer_o), .ready_o(ready_o), .finished_o(finished_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished_run = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0000;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd_o) mem_q <= memf(mem_addr_o);

  // serial master model
  int s_st = 0;
  int s_cnt = 0;
  always @(posedge clk) begin
    case (s_st)
      0: if (spi_arm_o) begin spi_ready <= 1'b0; s_cnt <= 1 + int'($urandom % 4); s_st <= 1; end
      1: if (s_cnt <= 1) begin spi_done <= 1'b1; s_st <= 2; end else s_cnt <= s_cnt - 1;
      2: if (!spi_arm_o) begin spi_done <= 1'b0; s_cnt <= int'($urandom % 3); s_st <= 3; end
      default: if (s_cnt == 0) begin spi_ready <= 1'b1; s_st <= 0; end else s_cnt <= s_cnt - 1;
    endcase
  end

  // monitor
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [AW-1:0] exp_base = '0;
  int     exp_len = 1, exp_sp = 0, exp_idx = 0;
  int     reads = 0, rises = 0, falls = 0;
  bit     have_fall = 0;
  longint fall_cyc = 0;
  logic [AW-1:0] last_addr = '0;
  logic   p_arm = 0, p_ready = 1;

  always @(negedge clk) if (!rst) begin
    if (mem_rd_o) begin
      chk(mem_addr_o == exp_base + AW'(exp_idx * 4), "R3 read address", mem_addr_o, exp_base + AW'(exp_idx * 4));
      chk(index_o == CW'(exp_idx), "R11 index at fetch", 32'(index_o), 32'(exp_idx));
      if (have_fall)
        chk(cyc - fall_cyc == longint'(exp_sp + 1), "R5 spacing gap", 32'(cyc - fall_cyc), 32'(exp_sp + 1));
      last_addr = mem_addr_o;
      reads++;
    end
    if (spi_arm_o && !p_arm) begin
      chk(p_ready, "R4 arm without ready", 32'(p_ready), 32'd1);
      chk(spi_data_o == memf(last_addr), "R3 data to serial", spi_data_o, memf(last_addr));
      rises++;
    end
    if (!spi_arm_o && p_arm) begin
      chk(spi_done, "R4 arm dropped early", 32'(spi_done), 32'd1);
      chk(timer_o == '0, "R6 timer cleared", 32'(timer_o), 32'd0);
      fall_cyc = cyc;
      have_fall = 1;
      falls++;
      exp_idx = (exp_idx + 1 >= exp_len) ? 0 : exp_idx + 1;
    end
    p_arm = spi_arm_o;
    p_ready = spi_ready;
  end

  task automatic play(input logic [AW-1:0] b, input int n, input int sp, input bit lp, input int want);
    bit saw_fin;
    @(negedge clk);
    base = b; wlen = CW'(n); spacing = TW'(sp); loop_en = lp;
    exp_base = b; exp_len = n; exp_sp = sp; exp_idx = 0;
    have_fall = 0; reads = 0; rises = 0; falls = 0;
    run = 1'b1;
    @(negedge clk);
    chk(!ready_o && mem_rd_o, "R2 start", {30'd0, ready_o, mem_rd_o}, 32'd1);
    if (!lp) begin
      while (!finished_o) @(negedge clk);
      chk(reads == n, "R7 read count", reads, n);
      repeat (4) @(negedge clk);
      chk(finished_o && !ready_o && reads == n, "R7 finished holds", {finished_o, ready_o}, 2'b10);
      run = 1'b0;
      @(negedge clk);
      chk(ready_o && !finished_o, "R7 back to ready", {finished_o, ready_o}, 2'b01);
    end else begin
      while (rises < want) @(negedge clk);
      run = 1'b0;
      saw_fin = 0;
      while (!ready_o) begin
        if (finished_o) saw_fin = 1;
        @(negedge clk);
      end
      chk(!saw_fin, "R9 no finished on stop", 32'(saw_fin), 32'd0);
      chk(reads == want, "R9 no read after stop", reads, want);
      chk(falls == want, "R8 loop transfers", falls, want);
    end
  endtask

  initial begin
    int seed;
    logic [TW-1:0] t1;
    seed = int'($urandom(32'h0000_5A17));
    repeat (3) @(negedge clk);
    chk(ready_o && !finished_o && !spi_arm_o && !mem_rd_o, "R1 status in reset",
        {finished_o, spi_arm_o, mem_rd_o, ready_o}, 32'd1);
    chk(index_o == '0 && timer_o == '0, "R1 counters in reset", {index_o, 8'd0, timer_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    t1 = timer_o;
    @(negedge clk);
    chk(timer_o == t1 + 1'b1, "R6 timer step", 32'(timer_o), 32'(t1 + 1'b1));
    repeat (300) @(negedge clk);
    chk(timer_o == '1, "R6 timer saturates", 32'(timer_o), 32'hFF);

    // empty table
    wlen = '0; run = 1'b1;
    @(negedge clk);
    chk(finished_o && !ready_o, "R10 empty finishes", {finished_o, ready_o}, 2'b10);
    repeat (3) @(negedge clk);
    chk(reads == 0 && rises == 0, "R10 no transfer", reads + rises, 0);
    run = 1'b0;
    @(negedge clk);
    chk(ready_o, "R7 ready after empty", 32'(ready_o), 32'd1);

    // directed
    play(32'h0000_0100, 3, 2, 1'b0, 0);
    play(32'h0000_0200, 1, 0, 1'b0, 0);
    play(32'h0000_0040, 2, 0, 1'b1, 5);
    play(32'h0000_0800, 3, 5, 1'b1, 2);

    // random
    for (int i = 0; i < 20; i++) begin
      int n, sp;
      bit lp;
      n  = 1 + int'($urandom % 6);
      sp = int'($urandom % 10);
      lp = 1'($urandom % 2);
      play({$urandom} & 32'h0000_FFFC, n, sp, lp, n + 1 + int'($urandom % 3));
    end
    finished_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule